// File: doc/BRIEF.md
# Dual-Channel Register-Programmed Pulse-Width Modulator

The block generates two independent pulse-width modulated outputs from one shared clock. Software programs it through a small 32-bit register bus. A single control word gives each channel one byte, and that byte holds a run-mode bit, an enable bit and an output-inversion bit. Each channel also has its own period word and its own high-time (duty) word, both counted in whole clock cycles.

While a channel runs, its counter steps through `0 .. period-1`. The output is active while the counter is below the duty value. Period and duty written by software are held in shadow registers. The channel copies them into its working registers only at a period boundary, or while it is stopped, so a running waveform never contains a truncated cycle. A period below two cycles is treated as invalid and holds the output inactive.

Top module: `pwm2ch_top`

## Requirements
- R1: A synchronous active-low reset clears the control, period and duty registers. After reset both outputs are low and every mapped register reads 0.
- R2: The control word sits at offset 0x00. The period register of channel n sits at 0x10+0x10·n and its duty register at 0x14+0x10·n. A read strobe returns the last written value of the addressed register on `bus_rdata` one cycle later.
- R3: A read of any other offset returns 0. A write to any other offset changes no register.
- R4: Channel n uses control bits [8n+7:8n]. Within that byte, bit 0 is enable, bit 4 is polarity and bit 7 is run mode. All other bits are stored and read back but have no effect.
- R5: A channel without both mode and enable set outputs its polarity bit and holds its counter at 0. When it is enabled again, it starts from counter 0.
- R6: A running channel with working period P≥2 and duty D repeats a P-cycle pattern. Its output is active in the cycles where the counter is below D. The first active cycle is the one right after the enabling write.
- R7: With the polarity bit set, the running waveform is inverted: the active phase is low and the inactive phase is high.
- R8: If duty ≥ period, the output is constantly active. If duty = 0, it is constantly inactive.
- R9: A working period of 0 or 1 holds the output at its inactive level and the counter at 0.
- R10: Newly written period and duty values take effect on a running channel only after the current period finishes.
- R11: The two channels are independent. Programming or running one does not change the output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; all counting is in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 2 | One modulated output per channel |

## Verification
Register writes land at the clock edge that samples `bus_wr`. A change in control therefore shows on `pwm_out` in the cycle right after that edge. Read data is due one cycle after the read strobe. Period and duty changes on a running channel appear only after the counter wraps. The bench drives inputs on falling edges and updates a per-channel model at every rising edge from the pre-edge register values. It compares both outputs on every falling edge, and it compares read data on the falling edge that follows the strobe's rising edge. Each check is tagged with the requirement that the channel's current state exercises.

// File: rtl/pwm2ch_pkg.sv
package pwm2ch_pkg;

  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned POL_BIT  = 4;
  localparam int unsigned MODE_BIT = 7;

  localparam logic [7:0] CTRL_OFS   = 8'h00;
  localparam logic [7:0] CH_BASE    = 8'h10;
  localparam logic [7:0] CH_STRIDE  = 8'h10;
  localparam logic [7:0] DUTY_DELTA = 8'h04;

  typedef struct packed {
    logic mode;
    logic pol;
    logic en;
  } chan_cfg_t;

  function automatic logic [7:0] per_ofs(input int unsigned ch);
    return CH_BASE + CH_STRIDE * 8'(ch);
  endfunction

  function automatic logic [7:0] duty_ofs(input int unsigned ch);
    return per_ofs(ch) + DUTY_DELTA;
  endfunction

endpackage

// File: rtl/pwm2ch_regs.sv
module pwm2ch_regs
  import pwm2ch_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output chan_cfg_t [NCH-1:0]          cfg,
  output logic [NCH-1:0][DATA_W-1:0]   shd_per,
  output logic [NCH-1:0][DATA_W-1:0]   shd_duty
);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_W'(CTRL_OFS)) begin
      ctrl_q <= bus_wdata;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_per[n]  <= '0;
        shd_duty[n] <= '0;
      end else if (bus_wr) begin
        if (bus_addr == ADDR_W'(per_ofs(n)))  shd_per[n]  <= bus_wdata;
        if (bus_addr == ADDR_W'(duty_ofs(n))) shd_duty[n] <= bus_wdata;
      end
    end
    assign cfg[n].en   = ctrl_q[8*n + EN_BIT];
    assign cfg[n].pol  = ctrl_q[8*n + POL_BIT];
    assign cfg[n].mode = ctrl_q[8*n + MODE_BIT];
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS)) rd_val = ctrl_q;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(per_ofs(n)))  rd_val = shd_per[n];
      if (bus_addr == ADDR_W'(duty_ofs(n))) rd_val = shd_duty[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/pwm2ch_chan.sv
module pwm2ch_chan
  import pwm2ch_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic [CNT_W-1:0] shd_per,
  input  logic [CNT_W-1:0] shd_duty,
  output logic             pwm,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] aper_o
);

  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, aper_q, aduty_q;
  logic             run, per_ok, wrap, active;

  assign run    = cfg.mode & cfg.en;
  assign per_ok = aper_q >= MIN_PER;
  assign wrap   = cnt_q == aper_q - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      aper_q  <= '0;
      aduty_q <= '0;
    end else if (!run || !per_ok || wrap) begin
      cnt_q   <= '0;
      aper_q  <= shd_per;
      aduty_q <= shd_duty;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign active = run & per_ok & (cnt_q < aduty_q);
  assign pwm    = active ^ cfg.pol;
  assign cnt_o  = cnt_q;
  assign aper_o = aper_q;

endmodule

// File: rtl/pwm2ch_top.sv
module pwm2ch_top
  import pwm2ch_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  chan_cfg_t [NCH-1:0]        cfg;
  logic [NCH-1:0][DATA_W-1:0] shd_per, shd_duty, chan_cnt, chan_aper;

  pwm2ch_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg(cfg), .shd_per(shd_per), .shd_duty(shd_duty)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    pwm2ch_chan #(.CNT_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[n]),
      .shd_per(shd_per[n]), .shd_duty(shd_duty[n]),
      .pwm(pwm_out[n]), .cnt_o(chan_cnt[n]), .aper_o(chan_aper[n])
    );
  end

endmodule

// File: rtl/pwm2ch_checker.sv
module pwm2ch_checker
  import pwm2ch_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NCH-1:0]             pwm_out,
  input chan_cfg_t [NCH-1:0]        cfg,
  input logic [NCH-1:0][DATA_W-1:0] shd_per,
  input logic [NCH-1:0][DATA_W-1:0] shd_duty,
  input logic [NCH-1:0][DATA_W-1:0] chan_cnt,
  input logic [NCH-1:0][DATA_W-1:0] chan_aper
);

  logic mapped;
  always_comb begin
    mapped = bus_addr == ADDR_W'(CTRL_OFS);
    for (int n = 0; n < NCH; n++)
      if (bus_addr == ADDR_W'(per_ofs(n)) || bus_addr == ADDR_W'(duty_ofs(n)))
        mapped = 1'b1;
  end

  assert_unmapped_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !mapped |=> $stable(cfg) && $stable(shd_per) && $stable(shd_duty));

  assert_unmapped_rd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !mapped |=> bus_rdata == '0);

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg[n].mode && cfg[n].en) |-> pwm_out[n] == cfg[n].pol);

    assert_counter_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg[n].mode && cfg[n].en) |=> chan_cnt[n] == '0);

    assert_counter_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_aper[n] >= DATA_W'(2) |-> chan_cnt[n] < chan_aper[n]);

    assert_short_period_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chan_aper[n] < DATA_W'(2) |-> pwm_out[n] == cfg[n].pol);
  end

endmodule

bind pwm2ch_top pwm2ch_checker #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pwm_out(pwm_out), .cfg(cfg), .shd_per(shd_per),
  .shd_duty(shd_duty), .chan_cnt(chan_cnt), .chan_aper(chan_aper)
);

// File: tb/tb_pwm2ch_top.sv
module tb_pwm2ch_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  // reference state
  logic [31:0] m_ctrl;
  logic [31:0] m_per[NCH], m_duty[NCH], m_cnt[NCH], m_ap[NCH], m_ad[NCH];
  logic [31:0] exp_rdata;
  bit          ch1_watch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm2ch_top dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  function automatic logic [31:0] reg_at(input logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h10) return m_per[0];
    if (a == 8'h14) return m_duty[0];
    if (a == 8'h20) return m_per[1];
    if (a == 8'h24) return m_duty[1];
    return 32'h0;
  endfunction

  function automatic bit m_run(input int n);
    return m_ctrl[8*n+7] && m_ctrl[8*n];
  endfunction

  function automatic bit m_pol(input int n);
    return m_ctrl[8*n+4];
  endfunction

  function automatic bit exp_out(input int n);
    bit act;
    act = m_run(n) && m_ap[n] >= 2 && m_cnt[n] < m_ad[n];
    return act ^ m_pol(n);
  endfunction

  function automatic string tag_for(input int n);
    if (!m_run(n)) return "R5";
    if (m_ap[n] < 2) return "R9";
    if (m_per[n] != m_ap[n] || m_duty[n] != m_ad[n]) return "R10";
    if (m_ad[n] >= m_ap[n] || m_ad[n] == 0) return "R8";
    if (m_pol(n)) return "R7";
    return "R6";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; exp_rdata = '0;
      for (int n = 0; n < NCH; n++) begin
        m_per[n] = '0; m_duty[n] = '0; m_cnt[n] = '0; m_ap[n] = '0; m_ad[n] = '0;
      end
    end else begin
      if (bus_rd) exp_rdata = reg_at(bus_addr);
      for (int n = 0; n < NCH; n++) begin
        if (!m_run(n) || m_ap[n] < 2 || m_cnt[n] == m_ap[n] - 1) begin
          m_cnt[n] = '0; m_ap[n] = m_per[n]; m_ad[n] = m_duty[n];
        end else m_cnt[n] = m_cnt[n] + 1;
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_ctrl = bus_wdata;
          8'h10: m_per[0] = bus_wdata;
          8'h14: m_duty[0] = bus_wdata;
          8'h20: m_per[1] = bus_wdata;
          8'h24: m_duty[1] = bus_wdata;
          default: ;
        endcase
      end
    end
    started = 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle output comparison
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      for (int n = 0; n < NCH; n++)
        check(tag_for(n), 32'(pwm_out[n]), 32'(exp_out(n)));
      if (ch1_watch) check("R11", 32'(pwm_out[1]), 32'(m_pol(1)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(tag, bus_rdata, exp_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rand_byte();
    logic [7:0] b;
    b = 8'($urandom);
    if ($urandom_range(0, 3) != 0) b = b & 8'h91;
    return b;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1", 32'(pwm_out), 32'h0);
    rd(8'h00, "R1"); check("R1", bus_rdata, 32'h0);
    rd(8'h10, "R1"); rd(8'h24, "R1");
    // R2: readback of every mapped register
    wr(8'h10, 32'd6); wr(8'h14, 32'd2); wr(8'h20, 32'd5); wr(8'h24, 32'd9);
    wr(8'h00, 32'h0000_AA5A);
    rd(8'h10, "R2"); check("R2", bus_rdata, 32'd6);
    rd(8'h24, "R2"); check("R2", bus_rdata, 32'd9);
    rd(8'h00, "R2"); check("R2", bus_rdata, 32'h0000_AA5A);
    // R3: unmapped writes and reads
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h18, 32'h1234); wr(8'h30, 32'h77);
    rd(8'h04, "R3"); check("R3", bus_rdata, 32'h0);
    rd(8'h00, "R3"); check("R3", bus_rdata, 32'h0000_AA5A);
    rd(8'h10, "R3"); rd(8'h14, "R3");
    // R4: enable without mode stays idle, then full enable, then inverted
    wr(8'h00, 32'h0000_0001); idle(6);
    check("R4", 32'(pwm_out[0]), 32'h0);
    wr(8'h00, 32'h0000_0081); idle(13);
    wr(8'h00, 32'h0000_0091); idle(13);
    // R11: ch1 idle while ch0 runs
    ch1_watch = 1; wr(8'h00, 32'h0000_1081); idle(20); ch1_watch = 0;
    // R10: change period mid-cycle
    wr(8'h10, 32'd8); wr(8'h14, 32'd3); idle(3);
    wr(8'h10, 32'd3); wr(8'h14, 32'd1); idle(20);
    // R9, R8 corners
    wr(8'h10, 32'd1); idle(10); wr(8'h10, 32'd0); idle(6);
    wr(8'h10, 32'd4); wr(8'h14, 32'd4); idle(10);
    wr(8'h14, 32'd0); idle(10);
    wr(8'h00, 32'h0000_8181); idle(20);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 9))
        0:    wr(8'h00, {16'($urandom), rand_byte(), rand_byte()});
        1, 2: wr(8'h10 + 8'($urandom_range(0, 1)) * 8'h10, 32'($urandom_range(0, 10)));
        3, 4: wr(8'h14 + 8'($urandom_range(0, 1)) * 8'h10, 32'($urandom_range(0, 12)));
        5:    rd(8'($urandom_range(0, 63)), "R2");
        6:    rd(8'($urandom) & 8'hFC, "R3");
        default: idle($urandom_range(1, 6));
      endcase
    end
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule